// File: doc/BRIEF.md
# MSI L1 Coherence Line Controller

This block is the coherence engine for one line of a private first-level cache that sits under a shared, inclusive second-level directory bank. It watches four inbound streams: processor accesses (load, instruction fetch, store, atomic), local eviction events (replacement or writeback), requests forwarded by the directory (invalidate-modified, invalidate-shared, downgrade), and grants returned by the directory (data, data-then-share, data-then-invalidate, put acknowledgement). It holds the line in one of four stable states or one of eight transient states and issues coherence requests and responses. It also signals completed processor accesses and presents the access permission that the data array must honour.

The transient states absorb races. An invalidate or a downgrade can arrive while a miss is still outstanding, and a grant can tell the line to drop back to shared or invalid as soon as the pending store has completed. Each output port is a one-entry registered slot with a valid/ready handshake. An inbound message is popped only in the cycle its transition fires. A transition fires only when every output slot it needs is empty. At most one inbound message is taken per cycle, in the fixed order grant, forwarded request, eviction, processor access.

Top module: `coh_line_ctrl`

## Requirements
- R1: Reset (synchronous, active high) puts the line in the not-present state and clears both output slots and the completion pulse. The `line_state` codes are NP=0, I=1, S=2, M=3, IS=4, ISI=5, IM=6, IMI=7, IMS=8, IMSI=9, SI=10, MI=11.
- R2: In any transient state (codes 4 to 11), processor accesses and evictions are not consumed. Their ready stays low and the state does not change.
- R3: The processor op codes are load=0, fetch=1, store=2 and atomic=3. The request codes are GETS=0, GET_INSTR=1, GETX=2, UPGRADE=3, PUTS=4, PUTX=5. From NP or I, a load sends GETS and enters IS, a fetch sends GET_INSTR and enters IS, and a store or atomic sends GETX and enters IM. The request carries `line_addr`.
- R4: In S, loads and fetches complete as loads, and a store or atomic sends UPGRADE and enters IM. In M, loads and fetches complete as loads and stores complete as stores, with no message and no state change.
- R5: An eviction in S sends PUTS and enters SI. In M it sends PUTX and enters MI. In NP or I it is consumed silently and leaves the line in NP.
- R6: The forwarded codes are invalidate-modified=0, invalidate-shared=1 and downgrade=2. The response codes are DATA=0 and INV_ACK=1, with `ack_from_buf`=0 for line data. In M, invalidate-modified sends DATA and enters I, and a downgrade sends DATA and enters S. In S, invalidate-shared sends INV_ACK and enters I.
- R7: The grant codes are DATA=0, DATA_S=1, DATA_I=2 and PUT_ACK=3. In IS, invalidate-shared sends INV_ACK and enters ISI. In IS, DATA completes the load and enters S, and DATA_I completes the load and enters I. In ISI, DATA completes the load and enters I.
- R8: In IM, invalidate-modified enters IMI with no response, a downgrade enters IMS, and invalidate-shared sends INV_ACK and stays in IM. In IMS, invalidate-shared enters IMSI with no response.
- R9: Every data grant in the IM family completes a store. IM with DATA enters M with no response. IM with DATA_S and IMS with DATA send DATA and enter S. IM with DATA_I, IMI with DATA and IMSI with DATA send DATA and enter I.
- R10: In MI, invalidate-modified sends DATA from the buffered copy (`ack_from_buf`=1) and stays in MI, and a downgrade does the same and enters SI. In SI, invalidate-shared sends INV_ACK and stays. PUT_ACK in SI or MI enters I.
- R11: `line_perm` is invalid=0 in NP, I, SI and MI, read-only=1 in S, read-write=2 in M, and busy=3 in the other transient states.
- R12: At most one inbound message is popped per cycle, with priority grant, forwarded request, eviction, processor access. A message waits while an output slot its transition needs is full, and an output slot holds its contents until accepted.
- R13: A forwarded request or grant that has no transition in the current state is popped and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_addr | input | ADDR_W | Address of the tracked line |
| cpu_valid | input | 1 | Processor access present |
| cpu_op | input | 2 | Processor access kind |
| cpu_ready | output | 1 | Processor access consumed this cycle |
| evict_valid | input | 1 | Replacement or writeback event present |
| evict_ready | output | 1 | Eviction consumed this cycle |
| fwd_valid | input | 1 | Forwarded directory request present |
| fwd_op | input | 2 | Forwarded request kind |
| fwd_ready | output | 1 | Forwarded request consumed this cycle |
| grant_valid | input | 1 | Directory grant present |
| grant_op | input | 2 | Grant kind |
| grant_ready | output | 1 | Grant consumed this cycle |
| req_valid | output | 1 | Outbound request slot full |
| req_op | output | 3 | Outbound request kind |
| req_addr | output | ADDR_W | Outbound request address |
| req_ready | input | 1 | Network accepts the request |
| ack_valid | output | 1 | Outbound response slot full |
| ack_op | output | 1 | Outbound response kind |
| ack_from_buf | output | 1 | Response data comes from the miss-tracking buffer |
| ack_addr | output | ADDR_W | Outbound response address |
| ack_ready | input | 1 | Network accepts the response |
| done_valid | output | 1 | One-cycle pulse: a processor access completed |
| done_store | output | 1 | The completed access was a store |
| line_state | output | 4 | Current coherence state |
| line_perm | output | 2 | Access permission of the line |

## Verification
The consume decision is combinational: the bench reads the ready for its input 1 ns after driving it at a falling edge, in the same cycle. The new state, the permission, the filled output slot and the completion pulse all come from registers loaded at the next rising edge, so the bench samples them at the falling edge that follows. The completion pulse lasts exactly one cycle and is only seen there. Output slots are drained one full cycle after each sample, except in the backpressure test, where a slot is deliberately left full for several cycles to show that a waiting access is held back until one cycle after the slot empties.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;

  typedef enum logic [3:0] {
    ST_NP = 4'd0, ST_I = 4'd1, ST_S = 4'd2, ST_M = 4'd3,
    ST_IS = 4'd4, ST_ISI = 4'd5, ST_IM = 4'd6, ST_IMI = 4'd7,
    ST_IMS = 4'd8, ST_IMSI = 4'd9, ST_SI = 4'd10, ST_MI = 4'd11
  } line_st_e;

  typedef enum logic [1:0] {CPU_LOAD, CPU_FETCH, CPU_STORE, CPU_ATOMIC} cpu_op_e;
  typedef enum logic [1:0] {FW_INV, FW_INV_S, FW_DOWNGRADE, FW_RSVD} fwd_op_e;
  typedef enum logic [1:0] {GR_DATA, GR_DATA_S, GR_DATA_I, GR_PUT_ACK} grant_op_e;
  typedef enum logic [2:0] {
    RQ_GETS, RQ_GET_INSTR, RQ_GETX, RQ_UPGRADE, RQ_PUTS, RQ_PUTX
  } req_op_e;
  typedef enum logic {RS_DATA, RS_INV_ACK} rsp_op_e;
  typedef enum logic [1:0] {PM_INVALID, PM_READ, PM_RW, PM_BUSY} perm_e;
  typedef enum logic [2:0] {EV_NONE, EV_CPU, EV_EVICT, EV_FWD, EV_GRANT} evt_e;

  localparam int REQ_OP_W = $bits(req_op_e);
  localparam int RSP_OP_W = $bits(rsp_op_e);

  typedef struct packed {
    line_st_e nxt;
    logic     req_en;
    req_op_e  req_op;
    logic     rsp_en;
    rsp_op_e  rsp_op;
    logic     rsp_buf;
    logic     done;
    logic     done_st;
  } action_t;

  function automatic logic is_transient(line_st_e st);
    return st >= ST_IS;
  endfunction

  function automatic perm_e perm_of(line_st_e st);
    case (st)
      ST_S:                   return PM_READ;
      ST_M:                   return PM_RW;
      ST_NP, ST_I, ST_SI, ST_MI: return PM_INVALID;
      default:                return PM_BUSY;
    endcase
  endfunction

endpackage

// File: rtl/coh_evt_pick.sv
module coh_evt_pick
  import coh_line_pkg::*;
(
  input  line_st_e st,
  input  logic     grant_v,
  input  logic     fwd_v,
  input  logic     evict_v,
  input  logic     cpu_v,
  output evt_e     evt
);
  logic settled;
  assign settled = !is_transient(st);

  // fixed priority: network grants, then forwarded requests, then local events
  always_comb begin
    if (grant_v)                 evt = EV_GRANT;
    else if (fwd_v)              evt = EV_FWD;
    else if (settled && evict_v) evt = EV_EVICT;
    else if (settled && cpu_v)   evt = EV_CPU;
    else                         evt = EV_NONE;
  end
endmodule

// File: rtl/coh_xition.sv
module coh_xition
  import coh_line_pkg::*;
(
  input  line_st_e  st,
  input  evt_e      evt,
  input  cpu_op_e   cpu_op,
  input  fwd_op_e   fwd_op,
  input  grant_op_e grant_op,
  output action_t   act
);
  logic wr;
  assign wr = (cpu_op == CPU_STORE) || (cpu_op == CPU_ATOMIC);

  always_comb begin
    act = '{nxt: st, req_en: 1'b0, req_op: RQ_GETS, rsp_en: 1'b0,
            rsp_op: RS_DATA, rsp_buf: 1'b0, done: 1'b0, done_st: 1'b0};
    case (evt)
      EV_CPU: begin
        case (st)
          ST_NP, ST_I: begin
            act.req_en = 1'b1;
            if (wr) begin act.req_op = RQ_GETX; act.nxt = ST_IM; end
            else begin
              act.req_op = (cpu_op == CPU_FETCH) ? RQ_GET_INSTR : RQ_GETS;
              act.nxt    = ST_IS;
            end
          end
          ST_S: begin
            if (wr) begin act.req_en = 1'b1; act.req_op = RQ_UPGRADE; act.nxt = ST_IM; end
            else act.done = 1'b1;
          end
          ST_M: begin act.done = 1'b1; act.done_st = wr; end
          default: ;
        endcase
      end
      EV_EVICT: begin
        case (st)
          ST_S: begin act.req_en = 1'b1; act.req_op = RQ_PUTS; act.nxt = ST_SI; end
          ST_M: begin act.req_en = 1'b1; act.req_op = RQ_PUTX; act.nxt = ST_MI; end
          default: act.nxt = ST_NP;
        endcase
      end
      EV_FWD: begin
        case (st)
          ST_M: if (fwd_op == FW_INV || fwd_op == FW_DOWNGRADE) begin
            act.rsp_en = 1'b1;
            act.nxt    = (fwd_op == FW_INV) ? ST_I : ST_S;
          end
          ST_S, ST_IS, ST_IM, ST_SI: if (fwd_op == FW_INV_S) begin
            act.rsp_en = 1'b1;
            act.rsp_op = RS_INV_ACK;
            if (st == ST_S)  act.nxt = ST_I;
            if (st == ST_IS) act.nxt = ST_ISI;
          end else if (st == ST_IM && fwd_op == FW_INV) act.nxt = ST_IMI;
          else if (st == ST_IM && fwd_op == FW_DOWNGRADE) act.nxt = ST_IMS;
          ST_IMS: if (fwd_op == FW_INV_S) act.nxt = ST_IMSI;
          ST_MI: if (fwd_op == FW_INV || fwd_op == FW_DOWNGRADE) begin
            act.rsp_en  = 1'b1;
            act.rsp_buf = 1'b1;
            if (fwd_op == FW_DOWNGRADE) act.nxt = ST_SI;
          end
          default: ;
        endcase
      end
      EV_GRANT: begin
        case (st)
          ST_IS: if (grant_op == GR_DATA || grant_op == GR_DATA_I) begin
            act.done = 1'b1;
            act.nxt  = (grant_op == GR_DATA) ? ST_S : ST_I;
          end
          ST_ISI: if (grant_op == GR_DATA) begin act.done = 1'b1; act.nxt = ST_I; end
          ST_IM: if (grant_op != GR_PUT_ACK) begin
            act.done = 1'b1; act.done_st = 1'b1;
            act.rsp_en = (grant_op != GR_DATA);
            act.nxt = (grant_op == GR_DATA) ? ST_M : (grant_op == GR_DATA_S) ? ST_S : ST_I;
          end
          ST_IMI, ST_IMS, ST_IMSI: if (grant_op == GR_DATA) begin
            act.done = 1'b1; act.done_st = 1'b1; act.rsp_en = 1'b1;
            act.nxt = (st == ST_IMS) ? ST_S : ST_I;
          end
          ST_SI, ST_MI: if (grant_op == GR_PUT_ACK) act.nxt = ST_I;
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_msg_slot.sv
module coh_msg_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end

  // R12: a full slot keeps its message until the consumer takes it
  a_r12_slot_hold: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(dout));
  // R12: the controller never loads a slot that is still full
  a_r12_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_line_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  output logic              cpu_ready,
  input  logic              evict_valid,
  output logic              evict_ready,
  input  logic              fwd_valid,
  input  logic [1:0]        fwd_op,
  output logic              fwd_ready,
  input  logic              grant_valid,
  input  logic [1:0]        grant_op,
  output logic              grant_ready,
  output logic              req_valid,
  output logic [2:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  output logic              ack_valid,
  output logic              ack_op,
  output logic              ack_from_buf,
  output logic [ADDR_W-1:0] ack_addr,
  input  logic              ack_ready,
  output logic              done_valid,
  output logic              done_store,
  output logic [3:0]        line_state,
  output logic [1:0]        line_perm
);
  localparam int REQ_W = REQ_OP_W + ADDR_W;
  localparam int RSP_W = 1 + RSP_OP_W + ADDR_W;

  line_st_e   st_q;
  perm_e      perm_q;
  evt_e       evt;
  action_t    act;
  logic       fire;
  logic [REQ_W-1:0] req_q;
  logic [RSP_W-1:0] rsp_q;

  coh_evt_pick u_pick (
    .st(st_q), .grant_v(grant_valid), .fwd_v(fwd_valid),
    .evict_v(evict_valid), .cpu_v(cpu_valid), .evt(evt)
  );

  coh_xition u_xition (
    .st(st_q), .evt(evt), .cpu_op(cpu_op_e'(cpu_op)),
    .fwd_op(fwd_op_e'(fwd_op)), .grant_op(grant_op_e'(grant_op)), .act(act)
  );

  // a transition fires only when every output slot it writes is empty
  assign fire = (evt != EV_NONE) && (!act.req_en || !req_valid) && (!act.rsp_en || !ack_valid);

  assign cpu_ready   = fire && (evt == EV_CPU);
  assign evict_ready = fire && (evt == EV_EVICT);
  assign fwd_ready   = fire && (evt == EV_FWD);
  assign grant_ready = fire && (evt == EV_GRANT);

  coh_msg_slot #(.W(REQ_W)) u_req_slot (
    .clk(clk), .rst(rst), .load(fire && act.req_en),
    .din({act.req_op, line_addr}), .ready(req_ready), .valid(req_valid), .dout(req_q)
  );

  coh_msg_slot #(.W(RSP_W)) u_rsp_slot (
    .clk(clk), .rst(rst), .load(fire && act.rsp_en),
    .din({act.rsp_buf, act.rsp_op, line_addr}), .ready(ack_ready), .valid(ack_valid), .dout(rsp_q)
  );

  assign req_op       = req_q[ADDR_W +: REQ_OP_W];
  assign req_addr     = req_q[ADDR_W-1:0];
  assign ack_from_buf = rsp_q[RSP_W-1];
  assign ack_op       = rsp_q[ADDR_W];
  assign ack_addr     = rsp_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_NP;
      perm_q     <= PM_INVALID;
      done_valid <= 1'b0;
      done_store <= 1'b0;
    end else begin
      done_valid <= fire && act.done;
      done_store <= fire && act.done_st;
      if (fire) begin
        st_q   <= act.nxt;
        perm_q <= perm_of(act.nxt);
      end
    end
  end

  assign line_state = st_q;
  assign line_perm  = perm_q;

  // R1: the first cycle out of reset shows an idle, empty line
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> st_q == ST_NP && !req_valid && !ack_valid && !done_valid);
  // R2: local events are never consumed while a transaction is in flight
  a_r2_stall_local: assert property (@(posedge clk) disable iff (rst)
    (st_q >= ST_IS) |-> !cpu_ready && !evict_ready);
  // R3: a miss from an idle line always leaves a request in the slot
  a_r3_miss_sends: assert property (@(posedge clk) disable iff (rst)
    cpu_ready && (st_q == ST_NP || st_q == ST_I) |=> req_valid);
  // R9: a data grant in the store-miss family always completes a store
  a_r9_store_done: assert property (@(posedge clk) disable iff (rst)
    grant_ready && grant_op == 2'd0 &&
    (st_q == ST_IM || st_q == ST_IMI || st_q == ST_IMS || st_q == ST_IMSI)
    |=> done_valid && done_store);
  // R11: write permission is held only in the modified state
  a_r11_rw_only_m: assert property (@(posedge clk) disable iff (rst)
    (perm_q == PM_RW) |-> st_q == ST_M);
  // R12: at most one inbound message is popped per cycle
  a_r12_one_pop: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_ready, evict_ready, fwd_ready, grant_ready}));
endmodule

// File: tb/coh_line_ctrl_tb_top.sv
module coh_line_ctrl_tb_top;
  localparam int AW = 32;
  localparam logic [AW-1:0] ADDR = 32'h0000_4C80;

  // kinds, ops, states, outcome codes as stated in the requirements
  localparam int KC = 0, KE = 1, KF = 2, KG = 3;
  localparam int LD = 0, FE = 1, STO = 2, AT = 3;
  localparam int FINV = 0, FINVS = 1, FDG = 2;
  localparam int GD = 0, GDS = 1, GDI = 2, GACK = 3;
  localparam int NP = 0, I = 1, S = 2, M = 3, IS = 4, ISI = 5, IM = 6, IMI = 7,
                 IMS = 8, IMSI = 9, SI = 10, MI = 11;
  localparam int QN = 7, QGETS = 0, QINS = 1, QGETX = 2, QUPG = 3, QPUTS = 4, QPUTX = 5;
  localparam int AN = 0, ADL = 1, ADB = 2, AIA = 3;
  localparam int DN = 0, DL = 1, DS = 2;

  function automatic logic [20:0] row(int r, int k, int o, int tk, int s,
                                      int rq, int rs, int dn, int rn);
    return {r[0], k[1:0], o[1:0], tk[0], s[3:0], rq[2:0], rs[1:0], dn[1:0], rn[3:0]};
  endfunction

  localparam int NV = 43;
  localparam logic [20:0] VEC [NV] = '{
    row(1, KC, LD,    1, IS,   QGETS, AN,  DN, 3),   // R3
    row(0, KC, STO,   0, IS,   QN,    AN,  DN, 2),   // R2
    row(0, KE, 0,     0, IS,   QN,    AN,  DN, 2),   // R2
    row(0, KF, FINVS, 1, ISI,  QN,    AIA, DN, 7),   // R7
    row(0, KG, GD,    1, I,    QN,    AN,  DL, 7),   // R7
    row(0, KC, FE,    1, IS,   QINS,  AN,  DN, 3),   // R3
    row(0, KG, GD,    1, S,    QN,    AN,  DL, 7),   // R7
    row(0, KC, FE,    1, S,    QN,    AN,  DL, 4),   // R4
    row(0, KC, AT,    1, IM,   QUPG,  AN,  DN, 4),   // R4
    row(0, KF, FINVS, 1, IM,   QN,    AIA, DN, 8),   // R8
    row(0, KF, FDG,   1, IMS,  QN,    AN,  DN, 8),   // R8
    row(0, KF, FINVS, 1, IMSI, QN,    AN,  DN, 8),   // R8
    row(0, KG, GD,    1, I,    QN,    ADL, DS, 9),   // R9
    row(0, KC, STO,   1, IM,   QGETX, AN,  DN, 3),   // R3
    row(0, KG, GD,    1, M,    QN,    AN,  DS, 9),   // R9
    row(0, KC, STO,   1, M,    QN,    AN,  DS, 4),   // R4
    row(0, KC, LD,    1, M,    QN,    AN,  DL, 4),   // R4
    row(0, KF, FDG,   1, S,    QN,    ADL, DN, 6),   // R6
    row(0, KE, 0,     1, SI,   QPUTS, AN,  DN, 5),   // R5
    row(0, KF, FINVS, 1, SI,   QN,    AIA, DN, 10),  // R10
    row(0, KG, GACK,  1, I,    QN,    AN,  DN, 10),  // R10
    row(0, KE, 0,     1, NP,   QN,    AN,  DN, 5),   // R5
    row(0, KC, STO,   1, IM,   QGETX, AN,  DN, 3),   // R3
    row(0, KF, FINV,  1, IMI,  QN,    AN,  DN, 8),   // R8
    row(0, KG, GD,    1, I,    QN,    ADL, DS, 9),   // R9
    row(0, KC, STO,   1, IM,   QGETX, AN,  DN, 3),   // R3
    row(0, KG, GDS,   1, S,    QN,    ADL, DS, 9),   // R9
    row(0, KF, FINVS, 1, I,    QN,    AIA, DN, 6),   // R6
    row(0, KC, AT,    1, IM,   QGETX, AN,  DN, 3),   // R3
    row(0, KG, GDI,   1, I,    QN,    ADL, DS, 9),   // R9
    row(0, KC, LD,    1, IS,   QGETS, AN,  DN, 3),   // R3
    row(0, KG, GDI,   1, I,    QN,    AN,  DL, 7),   // R7
    row(0, KC, STO,   1, IM,   QGETX, AN,  DN, 3),   // R3
    row(0, KG, GD,    1, M,    QN,    AN,  DS, 9),   // R9
    row(0, KE, 0,     1, MI,   QPUTX, AN,  DN, 5),   // R5
    row(0, KF, FINV,  1, MI,   QN,    ADB, DN, 10),  // R10
    row(0, KF, FDG,   1, SI,   QN,    ADB, DN, 10),  // R10
    row(0, KG, GACK,  1, I,    QN,    AN,  DN, 10),  // R10
    row(0, KC, STO,   1, IM,   QGETX, AN,  DN, 3),   // R3
    row(0, KG, GD,    1, M,    QN,    AN,  DS, 9),   // R9
    row(0, KF, FINV,  1, I,    QN,    ADL, DN, 6),   // R6
    row(0, KG, GACK,  1, I,    QN,    AN,  DN, 13),  // R13
    row(0, KF, FDG,   1, I,    QN,    AN,  DN, 13)   // R13
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_valid = 0, evict_valid = 0, fwd_valid = 0, grant_valid = 0;
  logic [1:0] cpu_op = 0, fwd_op = 0, grant_op = 0;
  logic req_ready = 0, ack_ready = 0;
  logic cpu_ready, evict_ready, fwd_ready, grant_ready;
  logic req_valid, ack_valid, ack_op, ack_from_buf, done_valid, done_store;
  logic [2:0] req_op;
  logic [AW-1:0] req_addr, ack_addr;
  logic [3:0] line_state;
  logic [1:0] line_perm;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [20:0] v;
  logic tk;

  always #2 clk = ~clk;

  coh_line_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .line_addr(ADDR),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ready(cpu_ready),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .fwd_valid(fwd_valid), .fwd_op(fwd_op), .fwd_ready(fwd_ready),
    .grant_valid(grant_valid), .grant_op(grant_op), .grant_ready(grant_ready),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_ready(req_ready),
    .ack_valid(ack_valid), .ack_op(ack_op), .ack_from_buf(ack_from_buf),
    .ack_addr(ack_addr), .ack_ready(ack_ready),
    .done_valid(done_valid), .done_store(done_store),
    .line_state(line_state), .line_perm(line_perm)
  );

  task automatic check(input int rn, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rn, what, act, exp);
    end
  endtask

  function automatic int perm_exp(int s);
    if (s == S) return 1;
    if (s == M) return 2;
    if (s == NP || s == I || s == SI || s == MI) return 0;
    return 3;
  endfunction

  function automatic logic [10:0] outcome();
    logic [2:0] q = req_valid ? req_op : 3'd7;
    logic [1:0] a = !ack_valid ? 2'd0 : ack_op ? 2'd3 : ack_from_buf ? 2'd2 : 2'd1;
    logic [1:0] d = !done_valid ? 2'd0 : done_store ? 2'd2 : 2'd1;
    return {line_state, q, a, d};
  endfunction

  task automatic drive(input int k, input int o, input logic on);
    case (k)
      KC: begin cpu_valid = on; cpu_op = o[1:0]; end
      KE: evict_valid = on;
      KF: begin fwd_valid = on; fwd_op = o[1:0]; end
      default: begin grant_valid = on; grant_op = o[1:0]; end
    endcase
  endtask

  function automatic logic taken_of(input int k);
    case (k)
      KC: return cpu_ready;
      KE: return evict_ready;
      KF: return fwd_ready;
      default: return grant_ready;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cpu_valid = 0; evict_valid = 0; fwd_valid = 0; grant_valid = 0;
    req_ready = 0; ack_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic drain();
    @(negedge clk); req_ready = 1; ack_ready = 1;
    @(negedge clk); req_ready = 0; ack_ready = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    check(1, "reset state", {line_state, line_perm, req_valid, ack_valid, done_valid}, 9'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v[20]) do_reset();
      @(negedge clk);
      drive(int'(v[19:18]), int'(v[17:16]), 1'b1);
      #1 tk = taken_of(int'(v[19:18]));
      @(negedge clk);
      check(int'(v[3:0]), $sformatf("vector %0d outcome", i),
            {21'd0, tk, outcome()}, {21'd0, v[15], v[14:11], v[10:8], v[7:6], v[5:4]});
      // R11: permission follows the state
      check(11, $sformatf("vector %0d permission", i), {30'd0, line_perm}, perm_exp(int'(v[14:11])));
      if (req_valid) check(3, "request address", req_addr, ADDR);
      drive(int'(v[19:18]), 0, 1'b0);
      drain();
    end

    // R12: priority grant > forwarded > eviction > processor
    do_reset();
    @(negedge clk); drive(KC, STO, 1);
    @(negedge clk); drive(KC, 0, 0); drain();
    @(negedge clk); drive(KF, FDG, 1); drive(KC, LD, 1);
    #1 check(12, "forwarded beats processor", {fwd_ready, cpu_ready}, 2'b10);
    @(negedge clk); drive(KF, 0, 0); drive(KC, 0, 0);
    check(12, "state after forwarded win", line_state, IMS);
    @(negedge clk); drive(KG, GD, 1); drive(KF, FINVS, 1);
    #1 check(12, "grant beats forwarded", {grant_ready, fwd_ready}, 2'b10);
    @(negedge clk); drive(KG, 0, 0); drive(KF, 0, 0);
    check(9, "IMS data outcome", outcome(), {4'(S), 3'd7, 2'd1, 2'd2});
    drain();
    @(negedge clk); drive(KE, 0, 1); drive(KC, LD, 1);
    #1 check(12, "eviction beats processor", {evict_ready, cpu_ready}, 2'b10);
    @(negedge clk); drive(KE, 0, 0); drive(KC, 0, 0);
    check(5, "evict from S", outcome(), {4'(SI), 3'(QPUTS), 2'd0, 2'd0});
    drain();

    // R12: full request slot holds a miss back and keeps its content
    do_reset();
    @(negedge clk); drive(KC, LD, 1);
    @(negedge clk); drive(KC, 0, 0);
    @(negedge clk); drive(KG, GDI, 1);
    @(negedge clk); drive(KG, 0, 0);
    check(7, "data-invalidate with slot full", {line_state, req_valid, 3'(req_op)}, {4'(I), 1'b1, 3'(QGETS)});
    drive(KC, STO, 1);
    for (int c = 0; c < 3; c++) begin
      #1 check(12, $sformatf("miss held by full slot, cycle %0d", c), {cpu_ready, line_state}, {1'b0, 4'(I)});
      @(negedge clk);
    end
    check(12, "held slot content", {req_valid, 3'(req_op)}, {1'b1, 3'(QGETS)});
    req_ready = 1;
    #1 check(12, "no pop in drain cycle", cpu_ready, 1'b0);
    @(negedge clk); req_ready = 0;
    #1 check(12, "pop after slot empties", cpu_ready, 1'b1);
    @(negedge clk); drive(KC, 0, 0);
    check(3, "miss after backpressure", {line_state, req_valid, 3'(req_op)}, {4'(IM), 1'b1, 3'(QGETX)});
    drain();

    finish_run();
  end
endmodule